// File: doc/BRIEF.md
# Complex Result Scaler and Halfword Output Selector

This block sits after a complex multiply-accumulate stage. It accepts one real and one imaginary result of `W` bits per transfer and scales both by the same power of two, picked by a 2-bit scale code. It can shift right by one or two places with sign fill, apply no shift, or shift left by one place. The two scaled words are kept in a single output register. A flag marks the case where a left shift has pushed a significant bit out of the top of either word.

Two `W/2`-bit ports, `pr` and `pi`, read the registered words through a four-way halfword selector. The select input has no register in its path, so a downstream reader can change it on every cycle while a result is held. This gives two readout schemes. In the first, `pr` and `pi` act as a real/imaginary pair and the high and low halves come out on two successive selections. In the second, the two ports together form one full word, first the real word and then the imaginary word.

The data input and the data output each use a valid/ready handshake. A result is accepted when `in_valid && in_ready`. While `out_valid` is high and `out_ready` is low, the output register keeps its contents and `in_ready` stays low, so back-pressure reaches the producer in the same cycle. When `out_ready` is high, a new result may enter in the same cycle that the old one leaves. The scale code is sampled together with the data. The output select is used without a register.

Top module: `cplx_result_scaler`

## Requirements
- R1: Scale code 00 passes each word through unchanged.
- R2: Scale code 01 shifts each word one place right arithmetically: bit W-1 is copied into the vacated top bit.
- R3: Scale code 10 shifts each word two places right arithmetically: bit W-1 is copied into the two vacated top bits.
- R4: Scale code 11 shifts each word one place left and puts a zero into bit 0.
- R5: `ovf` is set for a result if and only if the scale code is 11 and, for the real word or the imaginary word or both, bit W-1 differs from bit W-2. For scale codes 00, 01 and 10 `ovf` is low.
- R6: With `osel` 00, `pr`/`pi` show the upper halves of the real/imaginary words. With 01 they show the lower halves. With 10, `pr` shows the upper half and `pi` the lower half of the real word. With 11, `pr` shows the upper half and `pi` the lower half of the imaginary word. The upper half is bits W-1..W/2.
- R7: `osel` acts without a register. A change of `osel` alters `pr`/`pi` with no clock edge and with no new input transfer.
- R8: A result is accepted on a clock edge where `in_valid` and `in_ready` are both high, and it appears with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `in_ready` is low and the held result and `ovf` stay unchanged.
- R9: While `rst_n` is low, `out_valid` and `ovf` are low and `pr`/`pi` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input result valid |
| in_ready | output | 1 | Block can accept a result |
| in_re | input | W | Real result, two's complement |
| in_im | input | W | Imaginary result, two's complement |
| in_scale | input | 2 | Scale code, sampled with the data |
| out_valid | output | 1 | Held result valid |
| out_ready | input | 1 | Consumer takes the held result |
| osel | input | 2 | Halfword selection, not registered |
| pr | output | W/2 | First output halfword |
| pi | output | W/2 | Second output halfword |
| ovf | output | 1 | Left shift lost a significant bit in either word |

## Verification
The bench builds the block with `W = 8`, which gives 4-bit output ports. At this width every one of the 256 real input values can be driven under each of the four scale codes, with a companion imaginary value. Under each held result all four output selections are read back. This covers sign fill on every negative value, the full boundary between codes that overflow and codes that do not, and every halfword routing. One stall is also forced with a competing input, to show that the held result stays unchanged under back-pressure.

// File: rtl/cplx_scale_pkg.sv
package cplx_scale_pkg;
  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_RSH1 = 2'b01,
    SCL_RSH2 = 2'b10,
    SCL_LSH1 = 2'b11
  } scale_e;

  typedef enum logic [1:0] {
    SEL_MS_PAIR   = 2'b00,
    SEL_LS_PAIR   = 2'b01,
    SEL_REAL_WORD = 2'b10,
    SEL_IMAG_WORD = 2'b11
  } osel_e;
endpackage

// File: rtl/cplx_lane_shifter.sv
module cplx_lane_shifter
  import cplx_scale_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  scale_e       scale,
  output logic [W-1:0] y,
  output logic         bad
);
  // Sign fill for right shifts, zero fill for the left shift.
  always_comb begin
    case (scale)
      SCL_NONE: y = x;
      SCL_RSH1: y = {x[W-1], x[W-1:1]};
      SCL_RSH2: y = {{2{x[W-1]}}, x[W-1:2]};
      SCL_LSH1: y = {x[W-2:0], 1'b0};
      default:  y = x;
    endcase
  end

  // A left shift loses the sign when the top two bits disagree.
  assign bad = (scale == SCL_LSH1) && (x[W-1] != x[W-2]);
endmodule

// File: rtl/cplx_halfword_sel.sv
module cplx_halfword_sel
  import cplx_scale_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   re,
  input  logic [W-1:0]   im,
  input  osel_e          sel,
  output logic [W/2-1:0] pr,
  output logic [W/2-1:0] pi
);
  localparam int HW = W / 2;

  logic [HW-1:0] re_hi, re_lo, im_hi, im_lo;
  assign re_hi = re[W-1:HW];
  assign re_lo = re[HW-1:0];
  assign im_hi = im[W-1:HW];
  assign im_lo = im[HW-1:0];

  always_comb begin
    case (sel)
      SEL_MS_PAIR:   begin pr = re_hi; pi = im_hi; end
      SEL_LS_PAIR:   begin pr = re_lo; pi = im_lo; end
      SEL_REAL_WORD: begin pr = re_hi; pi = re_lo; end
      SEL_IMAG_WORD: begin pr = im_hi; pi = im_lo; end
      default:       begin pr = re_hi; pi = im_hi; end
    endcase
  end
endmodule

// File: rtl/cplx_result_scaler.sv
module cplx_result_scaler
  import cplx_scale_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_re,
  input  logic [W-1:0]   in_im,
  input  logic [1:0]     in_scale,
  output logic           out_valid,
  input  logic           out_ready,
  input  logic [1:0]     osel,
  output logic [W/2-1:0] pr,
  output logic [W/2-1:0] pi,
  output logic           ovf
);
  localparam int LANES = 2;  // lane 0 real, lane 1 imaginary

  logic [W-1:0] lane_in  [LANES];
  logic [W-1:0] lane_out [LANES];
  logic [W-1:0] held     [LANES];
  logic [LANES-1:0] lane_bad;
  scale_e scale_q;
  logic   take;

  assign lane_in[0] = in_re;
  assign lane_in[1] = in_im;
  assign scale_q    = scale_e'(in_scale);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cplx_lane_shifter #(.W(W)) u_shift (
      .x     (lane_in[g]),
      .scale (scale_q),
      .y     (lane_out[g]),
      .bad   (lane_bad[g])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ovf       <= 1'b0;
      for (int i = 0; i < LANES; i++) held[i] <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      ovf       <= |lane_bad;
      for (int i = 0; i < LANES; i++) held[i] <= lane_out[i];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  cplx_halfword_sel #(.W(W)) u_sel (
    .re  (held[0]),
    .im  (held[1]),
    .sel (osel_e'(osel)),
    .pr  (pr),
    .pi  (pi)
  );
endmodule

// File: rtl/cplx_result_scaler_chk.sv
module cplx_result_scaler_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_re,
  input logic [W-1:0]   in_im,
  input logic [1:0]     in_scale,
  input logic           out_valid,
  input logic           out_ready,
  input logic [1:0]     osel,
  input logic [W/2-1:0] pr,
  input logic [W/2-1:0] pi,
  input logic           ovf
);
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(ovf) && (!$stable(osel) || ($stable(pr) && $stable(pi)))));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_scale != 2'b11) |=> !ovf);

  assert_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_scale == 2'b11 &&
     ((in_re[W-1] != in_re[W-2]) || (in_im[W-1] != in_im[W-2]))) |=> ovf);

  always_comb begin
    if (!rst_n) assert_reset_R9: assert (!out_valid && !ovf);
  end
endmodule

bind cplx_result_scaler cplx_result_scaler_chk #(.W(W)) u_chk (.*);

// File: tb/cplx_result_scaler_test.sv
`timescale 1ns/100ps
module cplx_result_scaler_test;
  localparam int W  = 8;
  localparam int HW = W / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_re = '0, in_im = '0;
  logic [1:0]    in_scale = 2'b00;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [1:0]    osel = 2'b00;
  logic [HW-1:0] pr, pi;
  logic          ovf;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cplx_result_scaler #(.W(W)) uut (.*);

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] scaled(logic [W-1:0] x, int code);
    int v;
    v = $signed(x);
    case (code)
      0: return x;
      1: return W'(v >>> 1);
      2: return W'(v >>> 2);
      default: return W'(v * 2);
    endcase
  endfunction

  function automatic bit lost(logic [W-1:0] x);
    int v;
    v = $signed(x);
    return (v * 2 > (2 ** (W-1)) - 1) || (v * 2 < -(2 ** (W-1)));
  endfunction

  function automatic string code_tag(int code);
    case (code)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check_held(logic [W-1:0] er, logic [W-1:0] ei, int code);
    for (int s = 0; s < 4; s++) begin
      int xp, xi;
      string tag;
      osel = 2'(s);
      #0.2;
      case (s)
        0: begin xp = er[W-1:HW]; xi = ei[W-1:HW]; end
        1: begin xp = er[HW-1:0]; xi = ei[HW-1:0]; end
        2: begin xp = er[W-1:HW]; xi = er[HW-1:0]; end
        default: begin xp = ei[W-1:HW]; xi = ei[HW-1:0]; end
      endcase
      tag = (s == 0) ? {code_tag(code), " R6"} : {code_tag(code), " R6 R7"};
      chk({tag, " pr"}, int'(pr), xp);
      chk({tag, " pi"}, int'(pi), xi);
    end
  endtask

  task automatic xfer(logic [W-1:0] r, logic [W-1:0] m, int code);
    @(negedge clk);
    in_valid = 1'b1; in_re = r; in_im = m; in_scale = 2'(code); out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    chk("R8 out_valid", int'(out_valid), 1);
    chk("R5 ovf", int'(ovf), int'(code == 3 && (lost(r) || lost(m))));
    check_held(scaled(r, code), scaled(m, code), code);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R8 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 ovf", int'(ovf), 0);
    chk("R9 pr", int'(pr), 0);
    chk("R9 pi", int'(pi), 0);
    rst_n = 1'b1;

    for (int r = 0; r < 256; r++) begin
      for (int c = 0; c < 4; c++) begin
        xfer(W'(r), W'(r * 37 + 11), c);
      end
    end
    // imaginary-only overflow
    xfer(8'h10, 8'h80, 3);
    xfer(8'h10, 8'h20, 3);

    // stall: held result must survive a competing input
    xfer(8'h5A, 8'hC3, 1);
    @(negedge clk);
    in_valid = 1'b1; in_re = 8'h81; in_im = 8'h7F; in_scale = 2'b11;
    #0.2;
    chk("R8 in_ready low under stall", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 out_valid held", int'(out_valid), 1);
    chk("R8 ovf held", int'(ovf), 0);
    check_held(scaled(8'h5A, 1), scaled(8'hC3, 1), 1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8 drained", int'(out_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule